// File: doc/BRIEF.md
# Relocatable Internal RAM with Overlap Steering

This block holds a 32-Kbyte on-chip RAM for a processor with a 20-bit byte address bus. The RAM occupies a 32-Kbyte window, and a single control register places that window on any 32-Kbyte-aligned base. Each bus cycle is decoded against the window. An internal select is raised whenever the address falls inside the window and the register's enable bit is set. Accesses finish without wait states. Read data appears on the cycle after the request, which is the same timing a zero-wait external RAM has.

The block also receives the select of a low-memory external region. That region always starts at address zero, so placing the internal window at base zero, for example to keep the interrupt vectors in fast memory, makes the two regions overlap. In that case both selects fire. Reads return the internal data. Writes update the internal RAM and also drive the external write strobe, so the external device holds a copy. An optional show-read mode places internal read data on the external data bus. A flag reports an overlap with an external region that is not configured for zero wait states without a ready handshake.

A build parameter chooses between two organisations: 16-bit words with byte-lane enables, or 8-bit bytes. A second build parameter sets how much of the window is physically stored.

Top module: `iram_window`

## Requirements
- R1: After reset the control register reads back as 0x0000 at offset 0xAC, and the internal select is low.
- R2: While the enable bit (bit 6 of the register) is 0, the internal select stays low, and read data comes from the external read-data input.
- R3: With enable set, the internal select is high during a read or write cycle exactly when address bits 19:15 equal register bits 15:11, which form the window base.
- R4: A read inside the window returns the stored data on bus_rdata in the cycle after the request. A read outside the window returns ext_rdata in that same cycle.
- R5: When the external select and the internal select are both active on a read, bus_rdata returns the internal RAM data and not ext_rdata.
- R6: A write with the external select active drives ext_wr_out in the same cycle. If the address is also inside the window, the internal RAM is written too.
- R7: With show-read (bit 7 of the register) set, ext_dout_en is high and ext_dout carries the internal data in the response cycle of every internal read. Otherwise ext_dout_en stays low.
- R8: In the 16-bit organisation, bus_ben[1] enables the upper byte lane (data bits 15:8, the odd address) and bus_ben[0] enables the lower lane. A disabled lane keeps its old contents.
- R9: overlap_err is high in the same cycle that the internal select and ext_sel are both active while ext_zero_ws is 0. It is low otherwise.
- R10: The register is written only when reg_off is 0xAC. Writes at any other offset leave it unchanged, and reg_rdata returns 0 for offsets other than 0xAC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 8 | Register offset in the peripheral I/O space |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| bus_addr | input | 20 | Processor byte address |
| bus_rd | input | 1 | Read cycle |
| bus_wr | input | 1 | Write cycle |
| bus_ben | input | 2 | Byte-lane enables (16-bit organisation only) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after bus_rd |
| ext_sel | input | 1 | Low-memory external region select |
| ext_zero_ws | input | 1 | External region set to zero waits and no ready |
| ext_rdata | input | DW | External read data, in the response cycle |
| int_sel | output | 1 | Internal RAM select |
| ext_rd_out | output | 1 | External read strobe |
| ext_wr_out | output | 1 | External write strobe |
| ext_dout | output | DW | Data driven to the external bus in show-read mode |
| ext_dout_en | output | 1 | External data-bus drive enable |
| overlap_err | output | 1 | Misconfigured-overlap flag |

## Verification
Four outputs are combinational on the request cycle: int_sel, ext_rd_out, ext_wr_out and overlap_err. The bench reads them 1 ns after it drives inputs on the falling edge, which is before the edge that captures them. bus_rdata, ext_dout and ext_dout_en are due one rising edge after the read request. The bench samples them 1 ns after that edge and keeps the request inputs unchanged until the next falling edge. reg_rdata is combinational on reg_off and is checked in the same half-cycle in which the offset is driven.

// File: rtl/iram_pkg.sv
// Package: shared constants and the control-register type for the internal RAM.
// Assumes a 20-bit byte address and a 32-Kbyte window.
package iram_pkg;
    localparam int ADDR_W   = 20;
    localparam int WIN_LOG2 = 15;
    localparam int BASE_W   = ADDR_W - WIN_LOG2;
    localparam logic [7:0] CTL_OFFSET = 8'hAC;
    localparam int BASE_MSB = 15;
    localparam int BASE_LSB = BASE_MSB - BASE_W + 1;
    localparam int SHOW_BIT = 7;
    localparam int EN_BIT   = 6;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              show;
        logic              en;
    } iram_ctl_t;
endpackage

// File: rtl/iram_ctl_reg.sv
// Module: control register holding window base, show-read and enable.
// Assumes single-cycle register writes; readback is combinational on the offset.
module iram_ctl_reg
    import iram_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [7:0]  off,
    input  logic [15:0] wdata,
    output iram_ctl_t   ctl,
    output logic [15:0] rdata
);
    logic hit;
    assign hit = (off == CTL_OFFSET);

    // Capture register fields on a write to the control offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr && hit) begin
            ctl.base <= wdata[BASE_MSB:BASE_LSB];
            ctl.show <= wdata[SHOW_BIT];
            ctl.en   <= wdata[EN_BIT];
        end
    end

    // Rebuild the register image for readback.
    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[BASE_MSB:BASE_LSB] = ctl.base;
            rdata[SHOW_BIT]          = ctl.show;
            rdata[EN_BIT]            = ctl.en;
        end
    end
endmodule

// File: rtl/iram_decode.sv
// Module: window decode and external strobe steering.
// Assumes ext_sel comes from an external chip-select decoder on the same cycle.
module iram_decode
    import iram_pkg::*;
(
    input  logic              en,
    input  logic [BASE_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              ext_sel,
    input  logic              ext_zero_ws,
    output logic              int_sel,
    output logic              ext_rd,
    output logic              ext_wr,
    output logic              ovl_err
);
    // Compare the upper address bits with the programmed base and steer strobes.
    always_comb begin
        int_sel = en && (rd || wr) && (addr[ADDR_W-1:WIN_LOG2] == base);
        ext_rd  = rd && ext_sel;
        ext_wr  = wr && ext_sel;
        ovl_err = int_sel && ext_sel && !ext_zero_ws;
    end
endmodule

// File: rtl/iram_array.sv
// Module: byte-laned synchronous RAM with registered read data.
// Assumes one access per cycle; read and write share an index.
module iram_array #(
    parameter int LANES = 2,
    parameter int IDX_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               re,
    input  logic [IDX_W-1:0]   idx,
    input  logic [LANES-1:0]   lane_en,
    input  logic [LANES*8-1:0] wdata,
    output logic [LANES*8-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] mem [DEPTH];
        logic [7:0] q;

        // Write one byte lane when it is enabled.
        always_ff @(posedge clk) begin
            if (we && lane_en[l]) mem[idx] <= wdata[l*8 +: 8];
        end

        // Register the lane's read data.
        always_ff @(posedge clk) begin
            if (!rst_n)  q <= '0;
            else if (re) q <= mem[idx];
        end

        assign rdata[l*8 +: 8] = q;
    end
endmodule

// File: rtl/iram_window.sv
// Module: top of the relocatable internal RAM with overlap steering.
// Assumes the bus presents one read or write per cycle, and that external data
// for an external read arrives in the response cycle.
module iram_window
    import iram_pkg::*;
#(
    parameter bit WIDE16     = 1'b1,
    parameter int STORE_LOG2 = 12,
    localparam int DW        = WIDE16 ? 16 : 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_off,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_ben,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              ext_sel,
    input  logic              ext_zero_ws,
    input  logic [DW-1:0]     ext_rdata,
    output logic              int_sel,
    output logic              ext_rd_out,
    output logic              ext_wr_out,
    output logic [DW-1:0]     ext_dout,
    output logic              ext_dout_en,
    output logic              overlap_err
);
    localparam int LANES = DW / 8;
    localparam int LSB   = WIDE16 ? 1 : 0;
    localparam int IDX_W = STORE_LOG2 - LSB;

    iram_ctl_t         ctl_q;
    logic              ctl_en;
    logic [BASE_W-1:0] ctl_base;
    logic [LANES-1:0]  lane_en;
    logic [DW-1:0]     ram_q;
    logic              hit_q;
    logic              show_q;

    assign ctl_en   = ctl_q.en;
    assign ctl_base = ctl_q.base;

    iram_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .off   (reg_off),
        .wdata (reg_wdata),
        .ctl   (ctl_q),
        .rdata (reg_rdata)
    );

    iram_decode u_dec (
        .en          (ctl_q.en),
        .base        (ctl_q.base),
        .addr        (bus_addr),
        .rd          (bus_rd),
        .wr          (bus_wr),
        .ext_sel     (ext_sel),
        .ext_zero_ws (ext_zero_ws),
        .int_sel     (int_sel),
        .ext_rd      (ext_rd_out),
        .ext_wr      (ext_wr_out),
        .ovl_err     (overlap_err)
    );

    if (WIDE16) begin : g_w16
        assign lane_en = bus_ben;
    end else begin : g_w8
        assign lane_en = 1'b1;
    end

    iram_array #(.LANES(LANES), .IDX_W(IDX_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_wr && int_sel),
        .re      (bus_rd && int_sel),
        .idx     (bus_addr[STORE_LOG2-1:LSB]),
        .lane_en (lane_en),
        .wdata   (bus_wdata),
        .rdata   (ram_q)
    );

    // Remember whether the previous cycle was an internal read, and its show mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            show_q <= 1'b0;
        end else begin
            hit_q  <= bus_rd && int_sel;
            show_q <= ctl_q.show;
        end
    end

    // Steer the returned data and drive the external bus in show-read mode.
    always_comb begin
        bus_rdata   = hit_q ? ram_q : ext_rdata;
        ext_dout    = ram_q;
        ext_dout_en = hit_q && show_q;
    end
endmodule

// File: rtl/iram_window_chk.sv
// Module: assertion checker bound to iram_window.
// Assumes internal control fields are reachable through the bind connection.
module iram_window_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_en,
    input logic [4:0]  ctl_base,
    input logic [19:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic        ext_sel,
    input logic        ext_zero_ws,
    input logic        int_sel,
    input logic        ext_wr_out,
    input logic        ext_dout_en,
    input logic [15:0] ext_dout,
    input logic [15:0] bus_rdata,
    input logic        overlap_err
);
    p_sel_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_sel |-> ctl_en);

    p_sel_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int_sel |-> (bus_addr[19:15] == ctl_base));

    p_sel_needs_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int_sel |-> (bus_rd || bus_wr));

    p_write_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ext_sel) |-> ext_wr_out);

    p_show_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_dout_en |-> (ext_dout == bus_rdata));

    p_show_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_dout_en |-> $past(int_sel && bus_rd));

    p_overlap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err |-> (int_sel && ext_sel && !ext_zero_ws));
endmodule

bind iram_window iram_window_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_en      (ctl_en),
    .ctl_base    (ctl_base),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .ext_sel     (ext_sel),
    .ext_zero_ws (ext_zero_ws),
    .int_sel     (int_sel),
    .ext_wr_out  (ext_wr_out),
    .ext_dout_en (ext_dout_en),
    .ext_dout    (16'(ext_dout)),
    .bus_rdata   (16'(bus_rdata)),
    .overlap_err (overlap_err)
);

// File: tb/iram_window_tb_top.sv
// Bench: directed scenarios for iram_window, one task per scenario.
module iram_window_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_off = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [19:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_ben = 2'b11;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_sel = 1'b0;
    logic        ext_zero_ws = 1'b1;
    logic [15:0] ext_rdata = 16'h1234;
    logic        int_sel;
    logic        ext_rd_out;
    logic        ext_wr_out;
    logic [15:0] ext_dout;
    logic        ext_dout_en;
    logic        overlap_err;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    iram_window dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ben(bus_ben),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_sel(ext_sel),
        .ext_zero_ws(ext_zero_ws), .ext_rdata(ext_rdata), .int_sel(int_sel),
        .ext_rd_out(ext_rd_out), .ext_wr_out(ext_wr_out), .ext_dout(ext_dout),
        .ext_dout_en(ext_dout_en), .overlap_err(overlap_err)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] off, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_off = off; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_expect(input string tag, input logic [7:0] off, input logic [15:0] exp);
        @(negedge clk);
        reg_off = off;
        #1 check(tag, reg_rdata, exp);
    endtask

    // Write; samples combinational select/strobe/flag before the capturing edge.
    task automatic bus_write(input logic [19:0] a, input logic [15:0] d, input logic [1:0] be,
                             input logic es, output logic s_int, output logic s_ewr,
                             output logic s_err);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_ben = be; ext_sel = es; bus_wr = 1'b1;
        #1 s_int = int_sel; s_ewr = ext_wr_out; s_err = overlap_err;
        @(negedge clk);
        bus_wr = 1'b0; ext_sel = 1'b0;
    endtask

    // Read; response sampled 1 ns after the edge that follows the request.
    task automatic bus_read(input logic [19:0] a, input logic es, output logic s_int,
                            output logic [15:0] rd, output logic den, output logic [15:0] dq);
        @(negedge clk);
        bus_addr = a; ext_sel = es; bus_rd = 1'b1;
        #1 s_int = int_sel;
        @(posedge clk);
        #1 rd = bus_rdata; den = ext_dout_en; dq = ext_dout;
        @(negedge clk);
        bus_rd = 1'b0; ext_sel = 1'b0;
    endtask

    task automatic t_reset;
        logic si, sd, se; logic [15:0] r, q;
        reg_expect("R1 reg after reset", 8'hAC, 16'h0000);
        bus_read(20'h00000, 1'b0, si, r, sd, q);
        check("R1 int_sel after reset", {15'b0, si}, 16'h0);
        bus_read(20'h00010, 1'b1, si, r, sd, q);
        check("R2 disabled int_sel", {15'b0, si}, 16'h0);
        check("R2 disabled read from ext", r, 16'h1234);
        bus_write(20'h00010, 16'h7777, 2'b11, 1'b0, si, sd, se);
        check("R2 disabled write no select", {15'b0, si}, 16'h0);
    endtask

    task automatic t_register;
        reg_write(8'hAC, 16'h1840);
        reg_expect("R10 readback base 3 enabled", 8'hAC, 16'h1840);
        reg_write(8'hAA, 16'hFFFF);
        reg_expect("R10 other offset ignored", 8'hAC, 16'h1840);
        reg_expect("R10 other offset reads zero", 8'hA2, 16'h0000);
    endtask

    task automatic t_window;
        logic si, sd, se; logic [15:0] r, q;
        bus_write(20'h18010, 16'hBEEF, 2'b11, 1'b0, si, sd, se);
        check("R3 select inside window", {15'b0, si}, 16'h1);
        bus_read(20'h18010, 1'b0, si, r, sd, q);
        check("R4 internal read data", r, 16'hBEEF);
        check("R7 no show when disabled", {15'b0, sd}, 16'h0);
        bus_read(20'h20010, 1'b0, si, r, sd, q);
        check("R3 no select outside window", {15'b0, si}, 16'h0);
        check("R4 outside read from ext", r, 16'h1234);
        bus_read(20'h10010, 1'b0, si, r, sd, q);
        check("R3 no select one window below", {15'b0, si}, 16'h0);
        bus_read(20'h1FFFE, 1'b0, si, r, sd, q);
        check("R3 select at top of window", {15'b0, si}, 16'h1);
    endtask

    task automatic t_lanes;
        logic si, sd, se; logic [15:0] r, q;
        bus_write(20'h18011, 16'h55AA, 2'b10, 1'b0, si, sd, se);
        bus_read(20'h18010, 1'b0, si, r, sd, q);
        check("R8 upper lane only", r, 16'h55EF);
        bus_write(20'h18010, 16'h0011, 2'b01, 1'b0, si, sd, se);
        bus_read(20'h18010, 1'b0, si, r, sd, q);
        check("R8 lower lane only", r, 16'h5511);
    endtask

    task automatic t_overlap;
        logic si, sd, se; logic [15:0] r, q;
        reg_write(8'hAC, 16'h0040);
        ext_zero_ws = 1'b0;
        bus_write(20'h00100, 16'hCAFE, 2'b11, 1'b1, si, sd, se);
        check("R6 ext write strobe on overlap", {15'b0, sd}, 16'h1);
        check("R3 base zero select", {15'b0, si}, 16'h1);
        check("R9 flag with waits", {15'b0, se}, 16'h1);
        ext_zero_ws = 1'b1;
        bus_write(20'h00102, 16'h0F0F, 2'b11, 1'b1, si, sd, se);
        check("R9 no flag at zero waits", {15'b0, se}, 16'h0);
        bus_read(20'h00100, 1'b1, si, r, sd, q);
        check("R5 overlap read internal", r, 16'hCAFE);
        check("R6 internal copy written", r, 16'hCAFE);
        bus_write(20'h08100, 16'h3333, 2'b11, 1'b1, si, sd, se);
        check("R6 ext write outside window", {15'b0, sd}, 16'h1);
        check("R9 no flag without internal", {15'b0, se}, 16'h0);
    endtask

    task automatic t_show;
        logic si, sd, se; logic [15:0] r, q;
        reg_write(8'hAC, 16'h00C0);
        bus_read(20'h00100, 1'b0, si, r, sd, q);
        check("R7 show enable on internal read", {15'b0, sd}, 16'h1);
        check("R7 show data", q, 16'hCAFE);
        bus_read(20'h40000, 1'b1, si, r, sd, q);
        check("R7 no show on external read", {15'b0, sd}, 16'h0);
        check("R4 external read data", r, 16'h1234);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_register();
        t_window();
        t_lanes();
        t_overlap();
        t_show();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule